// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter with Signed Overflow Flag

This block moves a data word by any distance from zero up to one less than its width, in a single combinational pass with no clock. A direction input selects left or right. A two-bit mode input selects one of three operations. A logical shift fills the vacated positions with zeros. An arithmetic shift multiplies or divides a signed value by a power of two. A rotate feeds the bits that leave one end back in at the other.

The block sits in an execution datapath, next to an adder. An arithmetic left shift can produce a value that no longer equals the true signed product. In that case the block raises an overflow flag, so the surrounding logic can trap or saturate. The word width is a parameter, default 16, and must be a power of two. The distance input is log2(width) bits wide.

Top module: `barrel_shift_unit`

## Requirements
- R1: With mode 00 (logical) and `dir_right`=0, `data_out` is `data_in` moved up by `amount` places. Zeros fill the low positions, and bits pushed past the MSB are lost.
- R2: With mode 00 and `dir_right`=1, `data_out` is `data_in` moved down by `amount` places with zeros filling the high positions. This equals the floor of the unsigned quotient by 2^amount.
- R3: With mode 01 (arithmetic) and `dir_right`=1, the MSB of `data_in` is copied into every vacated high position. The result is the floor of the signed quotient by 2^amount, so -3 by 1 gives -2.
- R4: With mode 01 and `dir_right`=0, `data_out` equals the logical left result, with zeros filling the low positions.
- R5: With mode 01 and `dir_right`=0, `ovf` is 1 exactly when the top `amount`+1 bits of `data_in` are not all equal, i.e. when the result differs from the true signed product.
- R6: `ovf` is 0 for every combination other than mode 01 with `dir_right`=0.
- R7: With mode 10 (rotate) and `dir_right`=1, bits leaving position 0 re-enter at the MSB end, and no bit is lost.
- R8: With mode 10 and `dir_right`=0, bits leaving the MSB re-enter at position 0.
- R9: An `amount` of 0 returns `data_in` unchanged in every mode and direction, with `ovf` at 0.
- R10: Mode 11 is reserved and behaves exactly as mode 00 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be moved |
| amount | input | $clog2(WIDTH) | Number of bit positions, unsigned |
| dir_right | input | 1 | 1 = toward bit 0, 0 = toward the MSB |
| mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| data_out | output | WIDTH | Moved word |
| ovf | output | 1 | Signed overflow of an arithmetic left shift |

## Verification
On an arithmetic left shift the moved word and the overflow flag are produced from the same inputs together. Both must be right in the same sample. Vectors are chosen with the top bits of the input sitting just on either side of the overflow boundary: equal runs exactly `amount`+1 long, and runs one bit short. The word and the flag are compared together against values worked out from the requirement. A sweep over every distance, both directions and all four modes compares each result with shift operators and a bit-by-bit sign-run test that are written independently in the bench.

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] amount,
  input  logic             dir_right,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] data_out,
  output logic             ovf
);

  logic is_arith, is_rot, sign_fill;
  assign is_arith  = (mode == 2'b01);
  assign is_rot    = (mode == 2'b10);
  assign sign_fill = is_arith & data_in[WIDTH-1];

  logic [WIDTH-1:0] stg [AMT_W+1];
  assign stg[0] = data_in;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [SH-1:0]    fill_hi, fill_lo;
    logic [WIDTH-1:0] moved;
    assign fill_hi = is_rot ? stg[s][SH-1:0] : {SH{sign_fill}};
    assign fill_lo = is_rot ? stg[s][WIDTH-1:WIDTH-SH] : '0;
    assign moved   = dir_right ? {fill_hi, stg[s][WIDTH-1:SH]}
                               : {stg[s][WIDTH-SH-1:0], fill_lo};
    assign stg[s+1] = amount[s] ? moved : stg[s];
  end

  assign data_out = stg[AMT_W];

  assign ovf = is_arith & ~dir_right &
               (($signed(data_out) >>> amount) != $signed(data_in));

endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_in,
  input logic [AMT_W-1:0] amount,
  input logic             dir_right,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] data_out,
  input logic             ovf
);

  always_comb begin
    // R9
    zero_amount_chk: assert (amount != '0 || (data_out == data_in && !ovf))
      else $error("zero distance altered the word");
    // R6
    no_overflow_chk: assert (!ovf || (mode == 2'b01 && !dir_right))
      else $error("overflow flagged outside arithmetic left");
    // R7
    rotate_keep_chk: assert (mode != 2'b10 || $countones(data_out) == $countones(data_in))
      else $error("rotate lost or gained bits");
    // R2
    logic_right_chk: assert (!(mode == 2'b00 && dir_right) || data_out <= data_in)
      else $error("logical right grew the value");
    // R3
    sign_keep_chk: assert (!(mode == 2'b01 && dir_right) || data_out[WIDTH-1] == data_in[WIDTH-1])
      else $error("arithmetic right changed the sign");
  end

endmodule

bind barrel_shift_unit barrel_shift_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_barrel_shift_unit.sv
`timescale 1ns/1ps
module tb_barrel_shift_unit;
  localparam int W = 16;
  localparam int A = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] data_in = '0;
  logic [A-1:0] amount = '0;
  logic         dir_right = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] data_out;
  logic         ovf;

  barrel_shift_unit #(.WIDTH(W)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [W-1:0] din;
    logic [A-1:0] amt;
    logic         rt;
    logic [1:0]   md;
    logic [W-1:0] exp;
    logic         eovf;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 4'd4,  1'b0, 2'b00, 16'h2340, 1'b0, 4'd1},  // R1
    '{16'h8001, 4'd1,  1'b0, 2'b00, 16'h0002, 1'b0, 4'd1},  // R1
    '{16'hF0F0, 4'd4,  1'b1, 2'b00, 16'h0F0F, 1'b0, 4'd2},  // R2
    '{16'h8000, 4'd15, 1'b1, 2'b00, 16'h0001, 1'b0, 4'd2},  // R2
    '{16'hC000, 4'd1,  1'b1, 2'b01, 16'hE000, 1'b0, 4'd3},  // R3
    '{16'hC000, 4'd3,  1'b1, 2'b01, 16'hF800, 1'b0, 4'd3},  // R3
    '{16'hFFFD, 4'd1,  1'b1, 2'b01, 16'hFFFE, 1'b0, 4'd3},  // R3 -3 -> -2
    '{16'h7000, 4'd3,  1'b1, 2'b01, 16'h0E00, 1'b0, 4'd3},  // R3
    '{16'h8000, 4'd15, 1'b1, 2'b01, 16'hFFFF, 1'b0, 4'd3},  // R3
    '{16'h0003, 4'd2,  1'b0, 2'b01, 16'h000C, 1'b0, 4'd4},  // R4
    '{16'hFFFF, 4'd15, 1'b0, 2'b01, 16'h8000, 1'b0, 4'd5},  // R5 full run
    '{16'hC000, 4'd1,  1'b0, 2'b01, 16'h8000, 1'b0, 4'd5},  // R5
    '{16'hC000, 4'd2,  1'b0, 2'b01, 16'h0000, 1'b1, 4'd5},  // R5
    '{16'h4000, 4'd1,  1'b0, 2'b01, 16'h8000, 1'b1, 4'd5},  // R5
    '{16'h4000, 4'd1,  1'b0, 2'b00, 16'h8000, 1'b0, 4'd6},  // R6
    '{16'h8000, 4'd1,  1'b0, 2'b10, 16'h0001, 1'b0, 4'd8},  // R8
    '{16'h1234, 4'd4,  1'b0, 2'b10, 16'h2341, 1'b0, 4'd8},  // R8
    '{16'h1234, 4'd4,  1'b1, 2'b10, 16'h4123, 1'b0, 4'd7},  // R7
    '{16'h0001, 4'd1,  1'b1, 2'b10, 16'h8000, 1'b0, 4'd7},  // R7
    '{16'hABCD, 4'd0,  1'b0, 2'b01, 16'hABCD, 1'b0, 4'd9},  // R9
    '{16'hABCD, 4'd0,  1'b1, 2'b10, 16'hABCD, 1'b0, 4'd9},  // R9
    '{16'hF0F0, 4'd4,  1'b1, 2'b11, 16'h0F0F, 1'b0, 4'd10}, // R10
    '{16'h8001, 4'd1,  1'b0, 2'b11, 16'h0002, 1'b0, 4'd10}  // R10
  };

  task automatic check(input string req, input logic [W-1:0] ew, input logic eo);
    checks++;
    if (data_out !== ew || ovf !== eo) begin
      errors++;
      $display("FAIL %s: din=%h amt=%0d right=%0b mode=%b got %h/%0b expected %h/%0b",
               req, data_in, amount, dir_right, mode, data_out, ovf, ew, eo);
    end
  endtask

  function automatic logic [W-1:0] ref_word(input logic [W-1:0] d, input int k,
                                           input logic rt, input logic [1:0] md);
    logic [2*W-1:0] dbl;
    dbl = {d, d};
    if (md == 2'b10) begin
      if (rt) ref_word = W'(dbl >> k);
      else    ref_word = W'((dbl << k) >> W);
    end else if (md == 2'b01 && rt) ref_word = W'($signed(d) >>> k);
    else if (rt) ref_word = d >> k;
    else         ref_word = d << k;
  endfunction

  function automatic logic ref_ovf(input logic [W-1:0] d, input int k,
                                   input logic rt, input logic [1:0] md);
    ref_ovf = 1'b0;
    if (md == 2'b01 && !rt)
      for (int i = W-1-k; i < W; i++)
        if (d[i] != d[W-1]) ref_ovf = 1'b1;
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R9 idle", 16'h0000, 1'b0);
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      data_in = VECS[i].din; amount = VECS[i].amt;
      dir_right = VECS[i].rt; mode = VECS[i].md;
      @(negedge clk);
      check($sformatf("R%0d", VECS[i].req), VECS[i].exp, VECS[i].eovf);
    end
    // sweep: R1 R2 R3 R4 R5 R6 R7 R8 R10
    foreach (VECS[j]) ;
    for (int p = 0; p < 3; p++) begin
      for (int md = 0; md < 4; md++) begin
        for (int rt = 0; rt < 2; rt++) begin
          for (int k = 0; k < W; k++) begin
            logic [W-1:0] pat;
            pat = (p == 0) ? 16'hB5C3 : (p == 1) ? 16'h4A31 : 16'hF801;
            @(posedge clk);
            data_in = pat; amount = A'(k); dir_right = rt[0]; mode = md[1:0];
            @(negedge clk);
            check("R1-sweep-R10", ref_word(pat, k, rt[0], md[1:0]),
                  ref_ovf(pat, k, rt[0], md[1:0]));
          end
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule